// File: doc/BRIEF.md
# Decode-Stage Branch Hazard and Comparator Forwarding Unit

This unit sits beside the decode stage of a five-stage pipeline in which conditional branches compare their two source registers during decode. Each cycle it checks whether the branch in decode needs a value that no stage can supply yet. If so, it freezes the program counter and the fetch/decode register, and it turns the control word entering execute into a bubble.

When the needed value already exists in a later pipeline register, the unit steers it to the comparator instead. Each comparator operand has its own three-way multiplexer. It picks the register-file read, the ALU result held after the memory stage's input register, or the data value held in the writeback register. Every decision is made in the same cycle from the current stage contents, so the unit holds no state. A branch that depends on a load directly ahead of it therefore stays stalled for two cycles, as that load moves from execute to memory.

Top module: `dec_branch_hazard`

## Requirements
- R1: While a branch is in decode, if the instruction in execute writes a nonzero register that matches either branch source, `pc_write` is 0 for that cycle. This holds for a register-type producer and for a load alike.
- R2: While a branch is in decode, if the instruction in the memory stage is a load (`mem_is_load`=1) writing a matching nonzero register, `pc_write` is 0. Together with R1, a load directly ahead of the branch gives two consecutive stall cycles, and the branch then proceeds with a writeback forward.
- R3: A register-type instruction in the memory stage (`mem_is_load`=0) writing a matching nonzero register sets that operand's select to 1 (EX/MEM ALU result) and causes no stall.
- R4: A matching nonzero write in the writeback stage, from a load or a register-type instruction, sets that operand's select to 2 (MEM/WB data), provided the memory stage does not also match.
- R5: When the memory and writeback stages both match an operand, the memory stage wins: the select is 1 for a register-type producer. For a load producer the select is 0 and the unit stalls.
- R6: A producer with its write flag clear, or with destination register 0, never matches. It causes neither a stall nor a forward (select 0, the register file).
- R7: `ifid_write` always equals `pc_write`, and `idex_zero` is always its inverse.
- R8: With no branch in decode (`id_branch`=0), `pc_write` is 1 whatever the stage contents.
- R9: The two operand selects are decided independently. Select value 3 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_branch | input | 1 | A conditional branch occupies decode |
| id_src_a | input | REG_AW | First branch source register |
| id_src_b | input | REG_AW | Second branch source register |
| ex_wr | input | 1 | Instruction in execute writes a register |
| ex_dst | input | REG_AW | Destination register of the instruction in execute |
| mem_wr | input | 1 | Instruction in the memory stage writes a register |
| mem_is_load | input | 1 | Instruction in the memory stage is a load |
| mem_dst | input | REG_AW | Destination register in the memory stage |
| wb_wr | input | 1 | Instruction in writeback writes a register |
| wb_dst | input | REG_AW | Destination register in writeback |
| pc_write | output | 1 | Program counter may advance (0 = stall) |
| ifid_write | output | 1 | Fetch/decode register may load |
| idex_zero | output | 1 | Replace the control word entering execute by a bubble |
| cmp_sel_a | output | 2 | Operand A source: 0 register file, 1 EX/MEM, 2 MEM/WB |
| cmp_sel_b | output | 2 | Operand B source: 0 register file, 1 EX/MEM, 2 MEM/WB |

## Verification
A stall and a forward can fall in the same cycle when the two operands depend on different producers. One operand can wait on a load in the memory stage while the other already finds its value in writeback. The bench provokes this by pointing operand A at a load in memory and operand B at a writeback destination. It judges the result by requiring the stall outputs to be active while operand B's select is still 2 and operand A's select is 0. A second case pairs an execute-stage stall on one operand with a memory-stage forward on the other.

// File: rtl/dec_branch_hazard.sv
module dec_branch_hazard #(
  parameter int REG_AW = 5
) (
  input  logic              id_branch,
  input  logic [REG_AW-1:0] id_src_a,
  input  logic [REG_AW-1:0] id_src_b,
  input  logic              ex_wr,
  input  logic [REG_AW-1:0] ex_dst,
  input  logic              mem_wr,
  input  logic              mem_is_load,
  input  logic [REG_AW-1:0] mem_dst,
  input  logic              wb_wr,
  input  logic [REG_AW-1:0] wb_dst,
  output logic              pc_write,
  output logic              ifid_write,
  output logic              idex_zero,
  output logic [1:0]        cmp_sel_a,
  output logic [1:0]        cmp_sel_b
);
  localparam logic [1:0] SEL_RF    = 2'd0;
  localparam logic [1:0] SEL_EXMEM = 2'd1;
  localparam logic [1:0] SEL_MEMWB = 2'd2;

  function automatic logic hit(input logic wr, input logic [REG_AW-1:0] dst,
                               input logic [REG_AW-1:0] src);
    return wr && (dst != '0) && (dst == src);
  endfunction

  function automatic logic [1:0] pick(input logic mem_h, input logic mem_ld,
                                      input logic wb_h);
    if (mem_h && !mem_ld) return SEL_EXMEM;
    if (wb_h && !mem_h)   return SEL_MEMWB;
    return SEL_RF;
  endfunction

  logic ex_hit_a, ex_hit_b, mem_hit_a, mem_hit_b, wb_hit_a, wb_hit_b;
  logic stall;

  assign ex_hit_a  = hit(ex_wr,  ex_dst,  id_src_a);
  assign ex_hit_b  = hit(ex_wr,  ex_dst,  id_src_b);
  assign mem_hit_a = hit(mem_wr, mem_dst, id_src_a);
  assign mem_hit_b = hit(mem_wr, mem_dst, id_src_b);
  assign wb_hit_a  = hit(wb_wr,  wb_dst,  id_src_a);
  assign wb_hit_b  = hit(wb_wr,  wb_dst,  id_src_b);

  assign stall = id_branch &&
                 (ex_hit_a || ex_hit_b || (mem_is_load && (mem_hit_a || mem_hit_b)));

  assign pc_write   = !stall;
  assign ifid_write = !stall;
  assign idex_zero  = stall;

  assign cmp_sel_a = pick(mem_hit_a, mem_is_load, wb_hit_a);
  assign cmp_sel_b = pick(mem_hit_b, mem_is_load, wb_hit_b);
endmodule

// File: rtl/dec_branch_hazard_chk.sv
module dec_branch_hazard_chk #(
  parameter int REG_AW = 5
) (
  input logic              id_branch,
  input logic [REG_AW-1:0] id_src_a,
  input logic [REG_AW-1:0] id_src_b,
  input logic              ex_wr,
  input logic [REG_AW-1:0] ex_dst,
  input logic              mem_wr,
  input logic              mem_is_load,
  input logic [REG_AW-1:0] mem_dst,
  input logic              wb_wr,
  input logic [REG_AW-1:0] wb_dst,
  input logic              pc_write,
  input logic              ifid_write,
  input logic              idex_zero,
  input logic [1:0]        cmp_sel_a,
  input logic [1:0]        cmp_sel_b
);
  always_comb begin
    AST_IFID_TRACKS_PC: assert (ifid_write == pc_write); // R7
    AST_BUBBLE_INVERTS_PC: assert (idex_zero == !pc_write); // R7
    AST_IDLE_NEVER_STALLS: assert (id_branch || pc_write); // R8
    AST_SEL_A_LEGAL: assert (cmp_sel_a != 2'd3); // R9
    AST_SEL_B_LEGAL: assert (cmp_sel_b != 2'd3); // R9
    AST_EX_DEP_STALLS: assert (!(id_branch && ex_wr && ex_dst != '0 &&
                                 (ex_dst == id_src_a || ex_dst == id_src_b)) || !pc_write); // R1
    AST_MEM_LOAD_STALLS: assert (!(id_branch && mem_wr && mem_is_load && mem_dst != '0 &&
                                   (mem_dst == id_src_a || mem_dst == id_src_b)) || !pc_write); // R2
    AST_EXMEM_SRC_VALID: assert (cmp_sel_a != 2'd1 ||
                                 (mem_wr && !mem_is_load && mem_dst != '0 && mem_dst == id_src_a)); // R3
    AST_MEMWB_SRC_VALID: assert (cmp_sel_a != 2'd2 ||
                                 (wb_wr && wb_dst != '0 && wb_dst == id_src_a &&
                                  !(mem_wr && mem_dst == id_src_a))); // R4
  end
endmodule

bind dec_branch_hazard dec_branch_hazard_chk #(.REG_AW(REG_AW)) u_chk (
  .id_branch(id_branch), .id_src_a(id_src_a), .id_src_b(id_src_b),
  .ex_wr(ex_wr), .ex_dst(ex_dst), .mem_wr(mem_wr), .mem_is_load(mem_is_load),
  .mem_dst(mem_dst), .wb_wr(wb_wr), .wb_dst(wb_dst), .pc_write(pc_write),
  .ifid_write(ifid_write), .idex_zero(idex_zero), .cmp_sel_a(cmp_sel_a),
  .cmp_sel_b(cmp_sel_b)
);

// File: tb/test_dec_branch_hazard.sv
module test_dec_branch_hazard;
  logic clk = 0;
  logic rst = 1;
  always #4 clk = ~clk;

  logic       id_branch, ex_wr, mem_wr, mem_is_load, wb_wr;
  logic [4:0] id_src_a, id_src_b, ex_dst, mem_dst, wb_dst;
  logic       pc_write, ifid_write, idex_zero;
  logic [1:0] cmp_sel_a, cmp_sel_b;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  dec_branch_hazard i_dec_branch_hazard (
    .id_branch(id_branch), .id_src_a(id_src_a), .id_src_b(id_src_b),
    .ex_wr(ex_wr), .ex_dst(ex_dst), .mem_wr(mem_wr), .mem_is_load(mem_is_load),
    .mem_dst(mem_dst), .wb_wr(wb_wr), .wb_dst(wb_dst), .pc_write(pc_write),
    .ifid_write(ifid_write), .idex_zero(idex_zero), .cmp_sel_a(cmp_sel_a),
    .cmp_sel_b(cmp_sel_b)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle();
    id_branch = 0; id_src_a = 0; id_src_b = 0;
    ex_wr = 0; ex_dst = 0; mem_wr = 0; mem_is_load = 0; mem_dst = 0;
    wb_wr = 0; wb_dst = 0;
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  task automatic chk_stall(input string tag, input bit st);
    chk({tag, " pc_write"}, pc_write, !st);
    chk({"R7 ", tag, " ifid_write"}, ifid_write, pc_write);
    chk({"R7 ", tag, " idex_zero"}, idex_zero, !pc_write);
  endtask

  task automatic t_reset();
    idle(); settle();
    chk_stall("R8 reset", 0);
    chk("R9 reset sel_a", cmp_sel_a, 0);
    chk("R9 reset sel_b", cmp_sel_b, 0);
  endtask

  task automatic t_ex_dep();
    idle(); id_branch = 1; id_src_a = 5'd3; id_src_b = 5'd9;
    ex_wr = 1; ex_dst = 5'd9; settle();
    chk_stall("R1 ex rtype on b", 1);
    ex_dst = 5'd3; settle();
    chk_stall("R1 ex on a", 1);
    ex_dst = 5'd4; settle();
    chk_stall("R1 ex no match", 0);
  endtask

  task automatic t_load_sequence();
    idle(); id_branch = 1; id_src_a = 5'd7; id_src_b = 5'd1;
    ex_wr = 1; ex_dst = 5'd7; settle();
    chk_stall("R2 load in ex cycle1", 1);
    ex_wr = 0; ex_dst = 0; mem_wr = 1; mem_is_load = 1; mem_dst = 5'd7; settle();
    chk_stall("R2 load in mem cycle2", 1);
    chk("R5 load mem sel_a", cmp_sel_a, 0);
    mem_wr = 0; mem_is_load = 0; mem_dst = 0; wb_wr = 1; wb_dst = 5'd7; settle();
    chk_stall("R2 load in wb cycle3", 0);
    chk("R4 load wb sel_a", cmp_sel_a, 2);
    chk("R9 load wb sel_b", cmp_sel_b, 0);
  endtask

  task automatic t_mem_fwd();
    idle(); id_branch = 1; id_src_a = 5'd2; id_src_b = 5'd12;
    mem_wr = 1; mem_dst = 5'd12; settle();
    chk_stall("R3 mem rtype", 0);
    chk("R3 mem sel_b", cmp_sel_b, 1);
    chk("R9 mem sel_a", cmp_sel_a, 0);
  endtask

  task automatic t_wb_fwd();
    idle(); id_branch = 1; id_src_a = 5'd30; id_src_b = 5'd30;
    wb_wr = 1; wb_dst = 5'd30; settle();
    chk("R4 wb sel_a", cmp_sel_a, 2);
    chk("R4 wb sel_b", cmp_sel_b, 2);
    chk_stall("R4 wb", 0);
  endtask

  task automatic t_priority();
    idle(); id_branch = 1; id_src_a = 5'd6; id_src_b = 5'd6;
    mem_wr = 1; mem_dst = 5'd6; wb_wr = 1; wb_dst = 5'd6; settle();
    chk("R5 both match sel_a", cmp_sel_a, 1);
    chk("R5 both match sel_b", cmp_sel_b, 1);
    chk_stall("R5 both match", 0);
  endtask

  task automatic t_zero_and_nowrite();
    idle(); id_branch = 1; id_src_a = 0; id_src_b = 0;
    ex_wr = 1; mem_wr = 1; mem_is_load = 1; wb_wr = 1; settle();
    chk_stall("R6 dst zero", 0);
    chk("R6 dst zero sel_a", cmp_sel_a, 0);
    idle(); id_branch = 1; id_src_a = 5'd8; id_src_b = 5'd8;
    ex_dst = 5'd8; mem_dst = 5'd8; mem_is_load = 1; wb_dst = 5'd8; settle();
    chk_stall("R6 no write flag", 0);
    chk("R6 no write sel_b", cmp_sel_b, 0);
  endtask

  task automatic t_no_branch();
    idle(); id_src_a = 5'd5; id_src_b = 5'd5;
    ex_wr = 1; ex_dst = 5'd5; mem_wr = 1; mem_is_load = 1; mem_dst = 5'd5; settle();
    chk_stall("R8 no branch", 0);
  endtask

  task automatic t_mixed();
    idle(); id_branch = 1; id_src_a = 5'd10; id_src_b = 5'd11;
    mem_wr = 1; mem_is_load = 1; mem_dst = 5'd10; wb_wr = 1; wb_dst = 5'd11; settle();
    chk_stall("R2 mixed load stall", 1);
    chk("R9 mixed sel_a", cmp_sel_a, 0);
    chk("R9 mixed sel_b", cmp_sel_b, 2);
    idle(); id_branch = 1; id_src_a = 5'd13; id_src_b = 5'd14;
    ex_wr = 1; ex_dst = 5'd13; mem_wr = 1; mem_dst = 5'd14; settle();
    chk_stall("R1 mixed ex stall", 1);
    chk("R3 mixed sel_b", cmp_sel_b, 1);
  endtask

  initial begin
    idle();
    repeat (2) @(posedge clk);
    rst = 0;
    t_reset();
    t_ex_dep();
    t_load_sequence();
    t_mem_fwd();
    t_wb_fwd();
    t_priority();
    t_zero_and_nowrite();
    t_no_branch();
    t_mixed();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule